// File: doc/BRIEF.md
# In-Order Store Queue with Commit, Writeback and Retry

This block buffers store operations between allocation and the moment memory has taken them. Stores enter at the tail of a circular ring that has one more slot than its usable capacity, so the "full" and "empty" cases stay distinguishable. A commit input names the youngest retired sequence number. Every uncommitted store from the head onward with a sequence number at or below it gains write permission. The walk halts at the first younger store that has no permission yet.

A separate writeback pointer walks the permitted stores in program order. It offers them one per cycle on a memory request channel with valid/ready acceptance. A refused request is held and replayed when the memory raises its retry input. A store of size zero needs no memory access and is finished on the spot. Accepted stores finish when a response carrying their slot index comes back, in any order. Slots are released from the head only over an unbroken run of finished stores.

A squash trims uncommitted stores younger than a given sequence number from the tail backward. The block also reports how many new memory operations may be dispatched. That figure is the smaller of the free load slots, computed from a load-queue occupancy input, and the free store slots.

Top module: `store_queue`

## Requirements
- R1: After reset the queue is empty: `full` is 0, `alloc_ready` is 1, `mem_req_valid` is 0 and `free_slots` equals the smaller of SQ_CAP and LQ_CAP minus `lq_count`.
- R2: An accepted allocation is written at the tail and reports that slot on `alloc_idx`. Slot indices run 0 to SQ_CAP and wrap from SQ_CAP to 0. `full` is 1 exactly when SQ_CAP stores are held. `alloc_ready` is 0 when full or while `squash_valid` is 1.
- R3: `free_slots` equals min(LQ_CAP - `lq_count`, SQ_CAP - stores held). It updates in the cycle after any change to the occupancy.
- R4: A commit grants write permission, walking from the head, to every store whose sequence number is at most `commit_seq`. It stops at the first store without permission whose sequence number is larger.
- R5: Permitted stores are offered in slot order, at most one per cycle, with the slot index, address, data and size on the request outputs. Stores without permission are never offered.
- R6: A permitted store of size 0 produces no request. The writeback pointer passes it in one cycle, and its slot is freed like a completed store.
- R7: A request refused (valid without ready) blocks the channel: no request is offered until `mem_retry` is 1. The same store is then offered again, and the block clears only when that offer is accepted.
- R8: A response on `mem_rsp_idx` completes that outstanding store, in any order. The head advances over consecutive completed stores on the clock edge after the completion is recorded, and never past an uncompleted one.
- R9: A squash removes stores from the tail backward while their sequence number exceeds `squash_seq`. It stops at the first store holding write permission. The next allocation lands in the first removed slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_seq | input | SEQ_W | Sequence number of the new store |
| alloc_addr | input | ADDR_W | Store address |
| alloc_data | input | DATA_W | Store data |
| alloc_size | input | SIZE_W | Store size in bytes, 0 means no access |
| alloc_ready | output | 1 | Allocation accepted this cycle |
| alloc_idx | output | IDX_W | Slot the allocation is written to |
| full | output | 1 | Queue holds SQ_CAP stores |
| lq_count | input | LQ_W | Occupancy of the companion load queue |
| free_slots | output | FREE_W | Dispatchable memory operations |
| commit_valid | input | 1 | Commit event |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Squash event |
| squash_seq | input | SEQ_W | Stores younger than this are removed |
| mem_req_valid | output | 1 | Store request offered to memory |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_retry | input | 1 | Memory asks for the refused request again |
| mem_req_idx | output | IDX_W | Slot of the offered store |
| mem_req_addr | output | ADDR_W | Address of the offered store |
| mem_req_data | output | DATA_W | Data of the offered store |
| mem_req_size | output | SIZE_W | Size of the offered store |
| mem_rsp_valid | input | 1 | Completion response |
| mem_rsp_idx | input | IDX_W | Slot the response completes |

## Verification
A head pointer that slips past an unfinished store shows up one cycle after the completion, as `free_slots` rising too far. A stale writeback pointer or lost permission flag appears on the very next cycle: either a request for the wrong slot index or address, or no request where one is due. A blocked flag that clears early or late is seen at once on `mem_req_valid` while `mem_retry` is held low or high. A squash that crosses a committed store is caught through `free_slots` in the following cycle and through the slot returned by the next allocation.

// File: rtl/sq_pkg.sv
// Package sq_pkg
// Ring arithmetic shared by the store queue and its scanners.
// Assumes every ring position lies in 0..n-1 and |d| < n.
package sq_pkg;

    // Position reached after moving d slots (d may be negative) on a ring of n.
    function automatic int ring_add(input int p, input int d, input int n);
        return (p + d + n) % n;
    endfunction

    // Smaller of two integers.
    function automatic int min_int(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/sq_commit_scan.sv
// Module sq_commit_scan
// Walks the occupied slots from the head and selects the stores that a
// commit grants write permission to. Already-permitted stores are passed
// over; the first unpermitted store younger than the commit number ends
// the walk. Assumes sequence numbers do not wrap while in the queue.
module sq_commit_scan
    import sq_pkg::*;
#(
    parameter int N     = 5,
    parameter int IDX_W = 3,
    parameter int CNT_W = 3,
    parameter int SEQ_W = 8
) (
    input  logic [IDX_W-1:0]            head,
    input  logic [CNT_W-1:0]            count,
    input  logic                        commit_valid,
    input  logic [SEQ_W-1:0]            commit_seq,
    input  logic [N-1:0][SEQ_W-1:0]     seq,
    input  logic [N-1:0]                canwb,
    output logic [N-1:0]                set_mask,
    output logic [CNT_W-1:0]            n_set
);

    // Find the run of stores newly permitted by this commit.
    always_comb begin
        logic             stop;
        logic [IDX_W-1:0] pos;
        set_mask = '0;
        n_set    = '0;
        stop     = 1'b0;
        for (int i = 0; i < N; i++) begin
            pos = IDX_W'(ring_add(int'(head), i, N));
            if (commit_valid && (i < int'(count)) && !stop && !canwb[pos]) begin
                if (seq[pos] > commit_seq) begin
                    stop = 1'b1;
                end else begin
                    set_mask[pos] = 1'b1;
                    n_set         = n_set + CNT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/sq_squash_scan.sv
// Module sq_squash_scan
// Walks the occupied slots from the newest backward and selects the
// stores a squash removes. The walk ends at the first store that is not
// younger than the squash number or that already holds write permission.
module sq_squash_scan
    import sq_pkg::*;
#(
    parameter int N     = 5,
    parameter int IDX_W = 3,
    parameter int CNT_W = 3,
    parameter int SEQ_W = 8
) (
    input  logic [IDX_W-1:0]            tail,
    input  logic [CNT_W-1:0]            count,
    input  logic                        squash_valid,
    input  logic [SEQ_W-1:0]            squash_seq,
    input  logic [N-1:0][SEQ_W-1:0]     seq,
    input  logic [N-1:0]                canwb,
    output logic [N-1:0]                kill_mask,
    output logic [CNT_W-1:0]            n_kill
);

    // Find the young, uncommitted stores at the tail end.
    always_comb begin
        logic             stop;
        logic [IDX_W-1:0] pos;
        kill_mask = '0;
        n_kill    = '0;
        stop      = 1'b0;
        for (int i = 0; i < N; i++) begin
            pos = IDX_W'(ring_add(int'(tail), -1 - i, N));
            if (squash_valid && (i < int'(count)) && !stop) begin
                if (canwb[pos] || (seq[pos] <= squash_seq)) begin
                    stop = 1'b1;
                end else begin
                    kill_mask[pos] = 1'b1;
                    n_kill         = n_kill + CNT_W'(1);
                end
            end
        end
    end

    // A removed store must never hold write permission (R9).
    always_comb begin
        assert_squash_spares_committed_R9: assert ((kill_mask & canwb) == '0);
    end

endmodule

// File: rtl/sq_head_retire.sv
// Module sq_head_retire
// Counts the unbroken run of completed stores starting at the head; that
// run is released this cycle. Assumes done flags are registered state.
module sq_head_retire
    import sq_pkg::*;
#(
    parameter int N     = 5,
    parameter int IDX_W = 3,
    parameter int CNT_W = 3
) (
    input  logic [IDX_W-1:0]            head,
    input  logic [CNT_W-1:0]            count,
    input  logic [N-1:0]                done,
    output logic [N-1:0]                retire_mask,
    output logic [CNT_W-1:0]            n_retire
);

    // Measure the completed run at the head.
    always_comb begin
        logic             stop;
        logic [IDX_W-1:0] pos;
        retire_mask = '0;
        n_retire    = '0;
        stop        = 1'b0;
        for (int i = 0; i < N; i++) begin
            pos = IDX_W'(ring_add(int'(head), i, N));
            if ((i < int'(count)) && !stop) begin
                if (done[pos]) begin
                    retire_mask[pos] = 1'b1;
                    n_retire         = n_retire + CNT_W'(1);
                end else begin
                    stop = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/store_queue.sv
// Module store_queue
// Circular store queue with head, writeback and tail pointers. Stores are
// allocated at the tail, granted write permission by commit, sent in order
// from the writeback pointer on a valid/ready channel with retry, completed
// by indexed responses and released from the head in order.
// Assumes: responses only name outstanding slots, sequence numbers do not
// wrap while stores are queued, and lq_count never exceeds LQ_CAP.
module store_queue
    import sq_pkg::*;
#(
    parameter int SQ_CAP = 4,
    parameter int LQ_CAP = 4,
    parameter int SEQ_W  = 8,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int SIZE_W = 4,
    localparam int N      = SQ_CAP + 1,
    localparam int IDX_W  = $clog2(N),
    localparam int CNT_W  = $clog2(SQ_CAP + 1),
    localparam int LQ_W   = $clog2(LQ_CAP + 1),
    localparam int FREE_W = (CNT_W > LQ_W) ? CNT_W : LQ_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [SEQ_W-1:0]  alloc_seq,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic [DATA_W-1:0] alloc_data,
    input  logic [SIZE_W-1:0] alloc_size,
    output logic              alloc_ready,
    output logic [IDX_W-1:0]  alloc_idx,
    output logic              full,
    input  logic [LQ_W-1:0]   lq_count,
    output logic [FREE_W-1:0] free_slots,
    input  logic              commit_valid,
    input  logic [SEQ_W-1:0]  commit_seq,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    input  logic              mem_retry,
    output logic [IDX_W-1:0]  mem_req_idx,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_data,
    output logic [SIZE_W-1:0] mem_req_size,
    input  logic              mem_rsp_valid,
    input  logic [IDX_W-1:0]  mem_rsp_idx
);

    // Pointers and counters.
    logic [IDX_W-1:0] head_q, tail_q, wb_q;
    logic [CNT_W-1:0] cnt_q, pend_q;
    logic             blocked_q;

    // Slot contents and per-slot state.
    logic [N-1:0][SEQ_W-1:0]  seq_q;
    logic [N-1:0][ADDR_W-1:0] addr_q;
    logic [N-1:0][DATA_W-1:0] data_q;
    logic [N-1:0][SIZE_W-1:0] size_q;
    logic [N-1:0]             canwb_q, sent_q, done_q;

    // Scanner results.
    logic [N-1:0]     set_mask, kill_mask, retire_mask;
    logic [CNT_W-1:0] n_set, n_kill, n_retire;

    logic alloc_fire, wb_cand, wb_skip, req_accept, rsp_hit;

    sq_commit_scan #(.N(N), .IDX_W(IDX_W), .CNT_W(CNT_W), .SEQ_W(SEQ_W)) u_commit (
        .head(head_q), .count(cnt_q), .commit_valid(commit_valid),
        .commit_seq(commit_seq), .seq(seq_q), .canwb(canwb_q),
        .set_mask(set_mask), .n_set(n_set)
    );

    sq_squash_scan #(.N(N), .IDX_W(IDX_W), .CNT_W(CNT_W), .SEQ_W(SEQ_W)) u_squash (
        .tail(tail_q), .count(cnt_q), .squash_valid(squash_valid),
        .squash_seq(squash_seq), .seq(seq_q), .canwb(canwb_q | set_mask),
        .kill_mask(kill_mask), .n_kill(n_kill)
    );

    sq_head_retire #(.N(N), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_retire (
        .head(head_q), .count(cnt_q), .done(done_q),
        .retire_mask(retire_mask), .n_retire(n_retire)
    );

    // Allocation handshake and capacity reporting.
    always_comb begin
        full        = (cnt_q == CNT_W'(SQ_CAP));
        alloc_ready = !full && !squash_valid;
        alloc_fire  = alloc_valid && alloc_ready;
        alloc_idx   = tail_q;
        free_slots  = FREE_W'(min_int(LQ_CAP - int'(lq_count), SQ_CAP - int'(cnt_q)));
    end

    // Writeback candidate, zero-size skip and memory request.
    always_comb begin
        wb_cand       = (pend_q != '0) && (wb_q != tail_q) && canwb_q[wb_q];
        wb_skip       = wb_cand && (size_q[wb_q] == '0);
        mem_req_valid = wb_cand && !wb_skip && (!blocked_q || mem_retry);
        req_accept    = mem_req_valid && mem_req_ready;
        mem_req_idx   = wb_q;
        mem_req_addr  = addr_q[wb_q];
        mem_req_data  = data_q[wb_q];
        mem_req_size  = size_q[wb_q];
        rsp_hit       = mem_rsp_valid && sent_q[mem_rsp_idx] && !done_q[mem_rsp_idx];
    end

    // Pointer, counter and blocked-state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q    <= '0;
            tail_q    <= '0;
            wb_q      <= '0;
            cnt_q     <= '0;
            pend_q    <= '0;
            blocked_q <= 1'b0;
        end else begin
            head_q <= IDX_W'(ring_add(int'(head_q), int'(n_retire), N));
            if (alloc_fire) begin
                tail_q <= IDX_W'(ring_add(int'(tail_q), 1, N));
            end else begin
                tail_q <= IDX_W'(ring_add(int'(tail_q), -int'(n_kill), N));
            end
            if (wb_skip || req_accept) begin
                wb_q <= IDX_W'(ring_add(int'(wb_q), 1, N));
            end
            cnt_q  <= cnt_q + CNT_W'(alloc_fire) - n_retire - n_kill;
            pend_q <= pend_q + n_set - CNT_W'(wb_skip) - CNT_W'(rsp_hit);
            if (req_accept) begin
                blocked_q <= 1'b0;
            end else if (mem_req_valid) begin
                blocked_q <= 1'b1;
            end
        end
    end

    // Slot payload capture on allocation.
    always_ff @(posedge clk) begin
        if (alloc_fire) begin
            seq_q[tail_q]  <= alloc_seq;
            addr_q[tail_q] <= alloc_addr;
            data_q[tail_q] <= alloc_data;
            size_q[tail_q] <= alloc_size;
        end
    end

    // Per-slot permission, sent and done flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            canwb_q <= '0;
            sent_q  <= '0;
            done_q  <= '0;
        end else begin
            for (int s = 0; s < N; s++) begin
                if ((alloc_fire && (int'(tail_q) == s)) || kill_mask[s] || retire_mask[s]) begin
                    canwb_q[s] <= 1'b0;
                    sent_q[s]  <= 1'b0;
                    done_q[s]  <= 1'b0;
                end else begin
                    if (set_mask[s]) begin
                        canwb_q[s] <= 1'b1;
                    end
                    if (req_accept && (int'(wb_q) == s)) begin
                        sent_q[s] <= 1'b1;
                    end
                    if ((wb_skip && (int'(wb_q) == s)) ||
                        (rsp_hit && (int'(mem_rsp_idx) == s))) begin
                        done_q[s] <= 1'b1;
                    end
                end
            end
        end
    end

    // Full flag agrees with the ring pointers (R2).
    assert_full_matches_ring_R2: assert property (@(posedge clk) disable iff (!rst_n)
        full == (IDX_W'(ring_add(int'(tail_q), 1, N)) == head_q));

    // Permitted-but-unfinished stores never outnumber held stores (R4).
    assert_pending_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q <= cnt_q);

    // Only a permitted, not yet sent store is offered (R5).
    assert_req_permitted_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (canwb_q[wb_q] && !sent_q[wb_q] && !done_q[wb_q]));

    // A refusal blocks the channel and holds the pointer (R7).
    assert_refusal_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (blocked_q && (wb_q == $past(wb_q))));

    // Responses only name outstanding stores (R8).
    assert_rsp_outstanding_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |-> (sent_q[mem_rsp_idx] && !done_q[mem_rsp_idx]));

endmodule

// File: tb/store_queue_tb.sv
// Bench store_queue_tb: table-driven fill, then directed commit,
// writeback, retry, completion, squash and zero-size scenarios.
module store_queue_tb;

    localparam int CLK_P = 10;
    localparam int SQ_CAP = 4;
    localparam int LQ_CAP = 4;

    typedef struct packed {
        logic [7:0]  seq;
        logic [15:0] addr;
        logic [31:0] data;
        logic [3:0]  size;
        logic [2:0]  exp_idx;
        logic [2:0]  exp_free;
        logic        exp_full;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{8'd10, 16'h1000, 32'hA0A0_0001, 4'd4, 3'd0, 3'd3, 1'b0},
        '{8'd11, 16'h1040, 32'hB1B1_0002, 4'd8, 3'd1, 3'd2, 1'b0},
        '{8'd12, 16'h2000, 32'hC2C2_0003, 4'd2, 3'd2, 3'd1, 1'b0},
        '{8'd13, 16'h3000, 32'hD3D3_0004, 4'd1, 3'd3, 3'd0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 1'b0;
    logic [7:0]  alloc_seq = '0;
    logic [15:0] alloc_addr = '0;
    logic [31:0] alloc_data = '0;
    logic [3:0]  alloc_size = '0;
    logic        alloc_ready;
    logic [2:0]  alloc_idx;
    logic        full;
    logic [2:0]  lq_count = '0;
    logic [2:0]  free_slots;
    logic        commit_valid = 1'b0;
    logic [7:0]  commit_seq = '0;
    logic        squash_valid = 1'b0;
    logic [7:0]  squash_seq = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic        mem_retry = 1'b0;
    logic [2:0]  mem_req_idx;
    logic [15:0] mem_req_addr;
    logic [31:0] mem_req_data;
    logic [3:0]  mem_req_size;
    logic        mem_rsp_valid = 1'b0;
    logic [2:0]  mem_rsp_idx = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    store_queue #(.SQ_CAP(SQ_CAP), .LQ_CAP(LQ_CAP)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_seq(alloc_seq), .alloc_addr(alloc_addr),
        .alloc_data(alloc_data), .alloc_size(alloc_size),
        .alloc_ready(alloc_ready), .alloc_idx(alloc_idx), .full(full),
        .lq_count(lq_count), .free_slots(free_slots),
        .commit_valid(commit_valid), .commit_seq(commit_seq),
        .squash_valid(squash_valid), .squash_seq(squash_seq),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_retry(mem_retry), .mem_req_idx(mem_req_idx),
        .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data),
        .mem_req_size(mem_req_size),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_idx(mem_rsp_idx)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic alloc(input logic [7:0] s, input logic [15:0] a, input logic [3:0] sz,
                         input logic [2:0] exp_idx, input string tag);
        alloc_valid = 1'b1; alloc_seq = s; alloc_addr = a;
        alloc_data = {24'h5A5A5A, s}; alloc_size = sz;
        #1;
        chk({tag, " alloc_idx"}, 32'(alloc_idx), 32'(exp_idx));
        tick();
        alloc_valid = 1'b0;
    endtask

    task automatic commit(input logic [7:0] s);
        commit_valid = 1'b1; commit_seq = s;
        tick();
        commit_valid = 1'b0;
    endtask

    task automatic respond(input logic [2:0] idx);
        mem_rsp_valid = 1'b1; mem_rsp_idx = idx;
        tick();
        mem_rsp_valid = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) tick();
        // R1: reset state
        chk("R1 full", 32'(full), 0);
        chk("R1 alloc_ready", 32'(alloc_ready), 1);
        chk("R1 free_slots", 32'(free_slots), 4);
        chk("R1 mem_req_valid", 32'(mem_req_valid), 0);
        rst_n = 1'b1;

        // R2/R3: fill from the vector table
        foreach (VECS[i]) begin
            alloc_valid = 1'b1; alloc_seq = VECS[i].seq; alloc_addr = VECS[i].addr;
            alloc_data = VECS[i].data; alloc_size = VECS[i].size;
            #1;
            chk("R2 alloc_ready", 32'(alloc_ready), 1);
            chk("R2 alloc_idx", 32'(alloc_idx), 32'(VECS[i].exp_idx));
            tick();
            alloc_valid = 1'b0;
            #1;
            chk("R3 free_slots", 32'(free_slots), 32'(VECS[i].exp_free));
            chk("R2 full", 32'(full), 32'(VECS[i].exp_full));
        end
        alloc_valid = 1'b1;
        #1;
        chk("R2 refused when full", 32'(alloc_ready), 0);
        alloc_valid = 1'b0;
        lq_count = 3'd3;
        #1;
        chk("R3 min with load queue", 32'(free_slots), 0);
        lq_count = 3'd0;

        // R4/R5/R7: commit first two, refuse, retry
        commit(8'd11);
        #1;
        chk("R5 first request valid", 32'(mem_req_valid), 1);
        chk("R5 first request idx", 32'(mem_req_idx), 0);
        chk("R5 first request addr", 32'(mem_req_addr), 32'h1000);
        tick();
        chk("R7 quiet while blocked", 32'(mem_req_valid), 0);
        mem_retry = 1'b1;
        #1;
        chk("R7 resend on retry", 32'(mem_req_valid), 1);
        chk("R7 resend same idx", 32'(mem_req_idx), 0);
        tick();
        mem_retry = 1'b0;
        #1;
        chk("R7 still blocked after refused retry", 32'(mem_req_valid), 0);
        mem_retry = 1'b1; mem_req_ready = 1'b1;
        tick();
        mem_retry = 1'b0;
        #1;
        chk("R5 second request valid", 32'(mem_req_valid), 1);
        chk("R5 second request idx", 32'(mem_req_idx), 1);
        chk("R5 second request data", mem_req_data, 32'hB1B1_0002);
        chk("R5 second request size", 32'(mem_req_size), 8);
        tick();
        chk("R4 commit stopped at younger store", 32'(mem_req_valid), 0);
        mem_req_ready = 1'b0;

        // R8: out-of-order completion
        respond(3'd1);
        tick();
        chk("R8 head waits for oldest", 32'(free_slots), 0);
        respond(3'd0);
        chk("R8 release one cycle later", 32'(free_slots), 0);
        tick();
        chk("R8 head passes done run", 32'(free_slots), 2);

        // R9: squash stops at a committed store
        commit(8'd12);
        chk("R5 third request idx", 32'(mem_req_idx), 2);
        chk("R5 third request valid", 32'(mem_req_valid), 1);
        tick();
        squash_valid = 1'b1; squash_seq = 8'd5;
        alloc_valid = 1'b1; alloc_seq = 8'd30;
        #1;
        chk("R2 refused during squash", 32'(alloc_ready), 0);
        tick();
        squash_valid = 1'b0; alloc_valid = 1'b0;
        #1;
        chk("R9 only uncommitted removed", 32'(free_slots), 3);
        mem_retry = 1'b1; mem_req_ready = 1'b1;
        #1;
        chk("R7 held store resent", 32'(mem_req_idx), 2);
        tick();
        mem_retry = 1'b0;
        #1;
        chk("R9 squashed store not sent", 32'(mem_req_valid), 0);
        respond(3'd2);
        tick();
        chk("R8 queue drained", 32'(free_slots), 4);

        // R6: zero-size store, with ring wrap
        alloc(8'd20, 16'h4000, 4'd0, 3'd3, "R6");
        alloc(8'd21, 16'h4100, 4'd4, 3'd4, "R6");
        alloc(8'd22, 16'h4200, 4'd4, 3'd0, "R2 wrap");
        commit(8'd21);
        chk("R6 no request for zero size", 32'(mem_req_valid), 0);
        tick();
        chk("R6 pointer moved past", 32'(mem_req_idx), 4);
        chk("R6 next store offered", 32'(mem_req_valid), 1);
        chk("R6 next store addr", 32'(mem_req_addr), 32'h4100);
        tick();
        chk("R6 zero-size slot freed", 32'(free_slots), 2);
        mem_req_ready = 1'b0;
        respond(3'd4);
        tick();
        chk("R8 completion freed", 32'(free_slots), 3);
        squash_valid = 1'b1; squash_seq = 8'd21;
        tick();
        squash_valid = 1'b0;
        chk("R9 young store removed", 32'(free_slots), 4);
        alloc(8'd40, 16'h5000, 4'd4, 3'd0, "R9 tail rewound");

        summary();
        $finish;
    end

endmodule